// File: doc/BRIEF.md
# Serial Servo Command Decoder

This block takes 8-bit commands from a host over a three-wire serial link (shift clock, data, active-low latch strobe) and turns each latched command into digital enables for the switches of a disc-drive servo front end. The upper nibble of a command picks one of four register groups: focus switches, tracking gain with brake and shock-compensation enable, tracking and sled mode, and search and kick levels. The lower nibble supplies the new value for the chosen group.

The same nibble also selects which digital status line is presented on a single multiplexed status output. Two direct-control pins act on the decoded state without a serial transfer. A jump-direction pin reverses the active jump switch while it is low and returns both servo loops to closed-loop operation when it is released. A lock pin forces the sled loop open and the tracking gain high. All serial and direct-control pins are brought into the system clock domain through two-stage synchronizers, and their edges are detected there.

Top module: `servo_cmd_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, every register group clears: focus_sw, gain_sw, brake_sw, trk_sw, search_lvl and kick_lvl read zero, and the status selector points at group 0 (status_oe high, status_out = fzc_in).
- R2: Serial bits are taken on rising ser_clk edges, first bit into command bit 0. Only the last eight bits count. A command acts only on a falling edge of ser_lat_n, and shifting without that edge changes no output.
- R3: Command 0x0v sets focus_sw[3:0] to v[3:0].
- R4: Command 0x1v stores the gain pair from v[1:0] (gain_sw[0] from v[0]), brake_sw from v[2] and the shock-compensation enable from v[3].
- R5: Command 0x2v sets the tracking mode from v[3:2]: 00 all open, 01 closes trk_sw[0] (servo), 10 closes trk_sw[2] (forward jump), 11 closes trk_sw[3] (reverse jump), with dir_ctl_n high.
- R6: Command 0x2v sets the sled mode from v[1:0]: 00 all open, 01 closes trk_sw[1] (servo), 10 closes trk_sw[4] (forward feed), 11 closes trk_sw[5] (reverse feed).
- R7: Command 0x3v sets kick_lvl from v[1:0] and search_lvl from v[3:2].
- R8: The upper nibble of the last latched command selects status_out: 0 gives fzc_in, 1 gives shock_in, 2 gives tzc_in, 3 gives inlimit_in, with status_oe high. Nibbles 4 to 15 drive status_oe low and status_out low.
- R9: While dir_ctl_n is low, a forward jump mode closes trk_sw[3] and a reverse jump mode closes trk_sw[2].
- R10: A rising edge on dir_ctl_n sets both tracking mode and sled mode to servo (01).
- R11: When the shock-compensation enable is 1 and shock_in is high, both gain_sw bits are the inverse of the stored gain pair.
- R12: While sled_lock_n is low, trk_sw[1] is open and gain_sw reads 11, whatever is stored.
- R13: A command writes only its own group. Commands with an upper nibble of 4 or more write no group and change only the status selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from host |
| ser_dat | input | 1 | Serial data from host, bit 0 first |
| ser_lat_n | input | 1 | Latch strobe, command applied on its falling edge |
| dir_ctl_n | input | 1 | Direct jump-direction control, idle high |
| sled_lock_n | input | 1 | Sled overrun lock, active low |
| fzc_in | input | 1 | Focus zero-cross status |
| shock_in | input | 1 | Shock detector status |
| tzc_in | input | 1 | Tracking zero-cross status |
| inlimit_in | input | 1 | Inner-limit switch status |
| focus_sw | output | 4 | Focus switch enables |
| gain_sw | output | 2 | Effective tracking gain switch enables |
| brake_sw | output | 1 | Brake circuit enable |
| trk_sw | output | 6 | Tracking and sled switch enables |
| search_lvl | output | 2 | Focus search level |
| kick_lvl | output | 2 | Sled kick level |
| status_out | output | 1 | Multiplexed status |
| status_oe | output | 1 | Drive enable for status_out (low means high-impedance) |

## Verification
A falling latch strobe reaches the registers on the third rising clock edge after it: two synchronizer stages, then the register write. Edges on dir_ctl_n and sled_lock_n change the outputs two edges after the pin moves, and the automatic servo restore on release lands one edge later. The status multiplexer follows its four inputs within the same cycle. The bench waits at least six clock cycles after every strobe or pin change and samples on the falling clock edge, so each result is read well after it has settled and never at an active edge.

// File: rtl/servo_cmd_pkg.sv
// Shared types for the serial servo command decoder.
// Assumes 8-bit commands: upper nibble picks the group, lower nibble is data.
package servo_cmd_pkg;

    localparam int CMD_W   = 8;
    localparam int NIB_W   = 4;
    localparam int GRP_LSB = CMD_W - NIB_W;

    localparam logic [NIB_W-1:0] GRP_FOCUS = 4'h0;
    localparam logic [NIB_W-1:0] GRP_GAIN  = 4'h1;
    localparam logic [NIB_W-1:0] GRP_MODE  = 4'h2;
    localparam logic [NIB_W-1:0] GRP_LEVEL = 4'h3;

    typedef enum logic [1:0] {
        TRK_OFF   = 2'b00,
        TRK_SERVO = 2'b01,
        TRK_FWD   = 2'b10,
        TRK_REV   = 2'b11
    } trk_mode_e;

    typedef enum logic [1:0] {
        SLD_OFF   = 2'b00,
        SLD_SERVO = 2'b01,
        SLD_FWD   = 2'b10,
        SLD_REV   = 2'b11
    } sled_mode_e;

    typedef struct packed {
        logic [3:0]       fs;
        logic [1:0]       tg;
        logic             brake;
        logic             shock_en;
        trk_mode_e        trk;
        sled_mode_e       sled;
        logic [1:0]       kick;
        logic [1:0]       search;
        logic [NIB_W-1:0] sens_sel;
    } servo_regs_t;

endpackage

// File: rtl/sync_cell.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
// Assumes STAGES >= 2; each bit resets to its own value in RST_VAL.
module sync_cell #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[LAST];
endmodule

// File: rtl/serial_rx.sv
// Serial command receiver: synchronizes clock, data and strobe, shifts
// data on rising shift-clock edges (bit 0 first) and flags a command on
// each falling strobe edge. Assumes the shift clock is far slower than clk.
module serial_rx
    import servo_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_lat_n,
    output logic [CMD_W-1:0] cmd,
    output logic             cmd_valid
);
    logic ck_s, dt_s, lt_s;
    logic ck_d, lt_d;
    logic [CMD_W-1:0] shreg;

    sync_cell #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ser_clk, ser_dat, ser_lat_n}),
        .q    ({ck_s, dt_s, lt_s})
    );

    // edge history and shift register for incoming bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_d  <= 1'b0;
            lt_d  <= 1'b1;
            shreg <= '0;
        end else begin
            ck_d <= ck_s;
            lt_d <= lt_s;
            if (ck_s && !ck_d) shreg <= {dt_s, shreg[CMD_W-1:1]};
        end
    end

    assign cmd       = shreg;
    assign cmd_valid = lt_d && !lt_s;
endmodule

// File: rtl/cmd_regs.sv
// Command register file: writes the group named by the command's upper
// nibble, records the status selection, and restores both servo modes on
// release of the direct jump-direction pin (release wins over a command).
module cmd_regs
    import servo_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd,
    input  logic             cmd_valid,
    input  logic             dir_release,
    output servo_regs_t      regs
);
    servo_regs_t nxt;
    logic [NIB_W-1:0] grp;
    logic [NIB_W-1:0] val;

    assign grp = cmd[CMD_W-1:GRP_LSB];
    assign val = cmd[NIB_W-1:0];

    // next-state decode of one latched command
    always_comb begin
        nxt = regs;
        if (cmd_valid) begin
            nxt.sens_sel = grp;
            case (grp)
                GRP_FOCUS: nxt.fs = val;
                GRP_GAIN: begin
                    nxt.tg       = val[1:0];
                    nxt.brake    = val[2];
                    nxt.shock_en = val[3];
                end
                GRP_MODE: begin
                    nxt.trk  = trk_mode_e'(val[3:2]);
                    nxt.sled = sled_mode_e'(val[1:0]);
                end
                GRP_LEVEL: begin
                    nxt.kick   = val[1:0];
                    nxt.search = val[3:2];
                end
                default: ;
            endcase
        end
        if (dir_release) begin
            nxt.trk  = TRK_SERVO;
            nxt.sled = SLD_SERVO;
        end
    end

    // register update with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) regs <= '0;
        else        regs <= nxt;
    end
endmodule

// File: rtl/switch_map.sv
// Maps stored modes and synchronized direct pins to switch enables and
// the multiplexed status output. Purely combinational.
module switch_map
    import servo_cmd_pkg::*;
#(
    parameter int N_STATUS = 4
) (
    input  servo_regs_t         regs,
    input  logic                dir_hi,
    input  logic                lock_hi,
    input  logic                shock_in,
    input  logic [N_STATUS-1:0] status_vec,
    output logic [1:0]          gain_sw,
    output logic [5:0]          trk_sw,
    output logic                status_out,
    output logic                status_oe
);
    localparam int SEL_W = $clog2(N_STATUS);

    logic fwd_jump, rev_jump;

    assign fwd_jump = (regs.trk == TRK_FWD);
    assign rev_jump = (regs.trk == TRK_REV);

    // effective gain: shock inversion, then lock override
    always_comb begin
        gain_sw = regs.tg;
        if (regs.shock_en && shock_in) gain_sw = ~regs.tg;
        if (!lock_hi)                  gain_sw = 2'b11;
    end

    // tracking and sled switch enables with direction swap
    always_comb begin
        trk_sw[0] = (regs.trk == TRK_SERVO);
        trk_sw[1] = (regs.sled == SLD_SERVO) && lock_hi;
        trk_sw[2] = dir_hi ? fwd_jump : rev_jump;
        trk_sw[3] = dir_hi ? rev_jump : fwd_jump;
        trk_sw[4] = (regs.sled == SLD_FWD);
        trk_sw[5] = (regs.sled == SLD_REV);
    end

    // status source selection, high-impedance outside the listed groups
    always_comb begin
        status_oe  = (regs.sens_sel < N_STATUS);
        status_out = 1'b0;
        for (int i = 0; i < N_STATUS; i++) begin
            if (regs.sens_sel == NIB_W'(i)) status_out = status_vec[i];
        end
    end

    logic unused_sel;
    assign unused_sel = ^SEL_W;
endmodule

// File: rtl/servo_cmd_decoder.sv
// Top level of the serial servo command decoder. Receives host commands,
// keeps the four register groups and drives switch enables plus one
// multiplexed status line. Direct pins are synchronized here.
module servo_cmd_decoder
    import servo_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_dat,
    input  logic       ser_lat_n,
    input  logic       dir_ctl_n,
    input  logic       sled_lock_n,
    input  logic       fzc_in,
    input  logic       shock_in,
    input  logic       tzc_in,
    input  logic       inlimit_in,
    output logic [3:0] focus_sw,
    output logic [1:0] gain_sw,
    output logic       brake_sw,
    output logic [5:0] trk_sw,
    output logic [1:0] search_lvl,
    output logic [1:0] kick_lvl,
    output logic       status_out,
    output logic       status_oe
);
    logic [CMD_W-1:0] cmd;
    logic             cmd_valid;
    logic             dirc_q, lock_q, dirc_d;
    logic             dir_release;
    servo_regs_t      regs;

    serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .ser_lat_n(ser_lat_n),
        .cmd      (cmd),
        .cmd_valid(cmd_valid)
    );

    sync_cell #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({dir_ctl_n, sled_lock_n}),
        .q    ({dirc_q, lock_q})
    );

    // history of the direction pin for release detection
    always_ff @(posedge clk) begin
        if (!rst_n) dirc_d <= 1'b1;
        else        dirc_d <= dirc_q;
    end

    assign dir_release = dirc_q && !dirc_d;

    cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .cmd_valid  (cmd_valid),
        .dir_release(dir_release),
        .regs       (regs)
    );

    switch_map #(.N_STATUS(4)) u_map (
        .regs      (regs),
        .dir_hi    (dirc_q),
        .lock_hi   (lock_q),
        .shock_in  (shock_in),
        .status_vec({inlimit_in, tzc_in, shock_in, fzc_in}),
        .gain_sw   (gain_sw),
        .trk_sw    (trk_sw),
        .status_out(status_out),
        .status_oe (status_oe)
    );

    assign focus_sw   = regs.fs;
    assign brake_sw   = regs.brake;
    assign search_lvl = regs.search;
    assign kick_lvl   = regs.kick;
endmodule

// File: rtl/servo_cmd_chk.sv
// Property checker for servo_cmd_decoder, attached with bind below.
module servo_cmd_chk
    import servo_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        dirc_q,
    input logic        lock_q,
    input servo_regs_t regs,
    input logic [3:0]  focus_sw,
    input logic [1:0]  gain_sw,
    input logic        brake_sw,
    input logic [5:0]  trk_sw,
    input logic [1:0]  search_lvl,
    input logic [1:0]  kick_lvl,
    input logic        status_out,
    input logic        status_oe
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (focus_sw == 4'd0 && gain_sw == 2'd0 && !brake_sw &&
                    trk_sw == 6'd0 && search_lvl == 2'd0 && kick_lvl == 2'd0 &&
                    status_oe));

    // R2
    hold_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(focus_sw) && $stable(brake_sw) &&
                        $stable(search_lvl) && $stable(kick_lvl)));

    // R9
    swap_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dirc_q && regs.trk == TRK_FWD) |-> (trk_sw[3] && !trk_sw[2]));

    // R10
    dir_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirc_q) |=> (regs.trk == TRK_SERVO && regs.sled == SLD_SERVO));

    // R12
    lock_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |-> (!trk_sw[1] && gain_sw == 2'b11));

    // R8
    status_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.sens_sel[3:2] != 2'b00) |-> (!status_oe && !status_out));
endmodule

bind servo_cmd_decoder servo_cmd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .dirc_q    (dirc_q),
    .lock_q    (lock_q),
    .regs      (regs),
    .focus_sw  (focus_sw),
    .gain_sw   (gain_sw),
    .brake_sw  (brake_sw),
    .trk_sw    (trk_sw),
    .search_lvl(search_lvl),
    .kick_lvl  (kick_lvl),
    .status_out(status_out),
    .status_oe (status_oe)
);

// File: tb/servo_cmd_decoder_bench.sv
// Self-checking bench: sweeps every code of every group, both direct pins
// and all status selections against an arithmetic model.
module servo_cmd_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat_n = 1'b1;
    logic dir_ctl_n = 1'b1, sled_lock_n = 1'b1;
    logic fzc_in = 1'b0, shock_in = 1'b0, tzc_in = 1'b0, inlimit_in = 1'b0;
    logic [3:0] focus_sw;
    logic [1:0] gain_sw;
    logic       brake_sw;
    logic [5:0] trk_sw;
    logic [1:0] search_lvl, kick_lvl;
    logic       status_out, status_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [3:0] e_fs, e_sel;
    logic [1:0] e_tg, e_trk, e_sled, e_kick, e_srch;
    logic       e_brk, e_as;

    always #5 clk = ~clk;

    servo_cmd_decoder u_servo_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_lat_n(ser_lat_n), .dir_ctl_n(dir_ctl_n), .sled_lock_n(sled_lock_n),
        .fzc_in(fzc_in), .shock_in(shock_in), .tzc_in(tzc_in),
        .inlimit_in(inlimit_in), .focus_sw(focus_sw), .gain_sw(gain_sw),
        .brake_sw(brake_sw), .trk_sw(trk_sw), .search_lvl(search_lvl),
        .kick_lvl(kick_lvl), .status_out(status_out), .status_oe(status_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic model_reset();
        e_fs = 0; e_sel = 0; e_tg = 0; e_trk = 0; e_sled = 0;
        e_kick = 0; e_srch = 0; e_brk = 0; e_as = 0;
    endtask

    task automatic model_apply(input logic [7:0] b);
        e_sel = b[7:4];
        case (b[7:4])
            4'h0: e_fs = b[3:0];
            4'h1: begin e_tg = b[1:0]; e_brk = b[2]; e_as = b[3]; end
            4'h2: begin e_trk = b[3:2]; e_sled = b[1:0]; end
            4'h3: begin e_kick = b[1:0]; e_srch = b[3:2]; end
            default: ;
        endcase
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            ser_dat = b[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(2);
        end
    endtask

    task automatic strobe();
        ser_lat_n = 1'b0;
        tick(4);
        ser_lat_n = 1'b1;
        tick(6);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        send_bits(b, 8);
        strobe();
        model_apply(b);
    endtask

    task automatic check_all(input string req);
        logic [1:0] tg;
        logic [5:0] tw;
        logic       oe, so;
        logic [18:0] got, exp;
        @(negedge clk);
        tg = (e_as && shock_in) ? ~e_tg : e_tg;
        if (!sled_lock_n) tg = 2'b11;
        tw[0] = (e_trk == 2'd1);
        tw[1] = (e_sled == 2'd1) && sled_lock_n;
        tw[2] = dir_ctl_n ? (e_trk == 2'd2) : (e_trk == 2'd3);
        tw[3] = dir_ctl_n ? (e_trk == 2'd3) : (e_trk == 2'd2);
        tw[4] = (e_sled == 2'd2);
        tw[5] = (e_sled == 2'd3);
        oe = (e_sel < 4'd4);
        case (e_sel)
            4'd0: so = fzc_in;
            4'd1: so = shock_in;
            4'd2: so = tzc_in;
            4'd3: so = inlimit_in;
            default: so = 1'b0;
        endcase
        exp = {e_fs, tg, e_brk, tw, e_srch, e_kick, so, oe};
        got = {focus_sw, gain_sw, brake_sw, trk_sw, search_lvl, kick_lvl,
               status_out, status_oe};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check_all("R1 reset state");

        // R2: bit order, no effect without strobe, last eight bits count
        send_cmd(8'h05);
        check_all("R2 first command");
        send_bits(8'h0A, 8);
        tick(6);
        check_all("R2 shift without latch");
        strobe();
        model_apply(8'h0A);
        check_all("R2 latch after shift");
        send_bits(8'hFF, 3);
        send_cmd(8'h03);
        check_all("R2 overlong frame");

        // R3: focus group sweep
        for (int c = 0; c < 16; c++) begin
            send_cmd(8'h00 | 8'(c));
            check_all("R3 focus");
        end

        // R4 and R11: gain group with shock input both ways
        for (int c = 0; c < 16; c++) begin
            send_cmd(8'h10 | 8'(c));
            for (int s = 0; s < 2; s++) begin
                shock_in = s[0];
                tick(2);
                check_all("R4 R11 gain and shock");
            end
        end
        shock_in = 1'b0;

        // R12: lock pin over stored gain and sled servo
        send_cmd(8'h11);
        send_cmd(8'h25);
        check_all("R6 before lock");
        sled_lock_n = 1'b0;
        tick(6);
        check_all("R12 lock low");
        sled_lock_n = 1'b1;
        tick(6);
        check_all("R12 lock released");

        // R5 R6: mode sweep with direction pin high
        for (int c = 0; c < 16; c++) begin
            send_cmd(8'h20 | 8'(c));
            check_all("R5 R6 mode dir high");
        end
        // R9: mode sweep with direction pin low
        dir_ctl_n = 1'b0;
        tick(6);
        for (int c = 0; c < 16; c++) begin
            send_cmd(8'h20 | 8'(c));
            check_all("R9 mode dir low");
        end
        // R10: release restores servo on both loops
        send_cmd(8'h28);
        check_all("R9 forward jump swapped");
        dir_ctl_n = 1'b1;
        tick(6);
        e_trk = 2'd1;
        e_sled = 2'd1;
        check_all("R10 release to servo");

        // R7: level group sweep
        for (int c = 0; c < 16; c++) begin
            send_cmd(8'h30 | 8'(c));
            check_all("R7 levels");
        end

        // R13: groups stay independent, high nibbles write nothing
        send_cmd(8'h09);
        send_cmd(8'h16);
        send_cmd(8'h2E);
        send_cmd(8'h3B);
        check_all("R13 groups independent");
        send_cmd(8'h5F);
        check_all("R13 nibble 5 no write");
        send_cmd(8'hAF);
        check_all("R13 nibble A no write");

        // R8: status selection over every nibble and one-hot sources
        for (int n = 0; n < 16; n++) begin
            send_cmd(8'(n << 4));
            for (int p = 0; p < 5; p++) begin
                {inlimit_in, tzc_in, shock_in, fzc_in} = (p == 4) ? 4'hF : 4'(1 << p);
                tick(2);
                check_all("R8 status select");
            end
        end
        {inlimit_in, tzc_in, shock_in, fzc_in} = 4'h0;

        // R1: reset again from a busy state
        send_cmd(8'h1F);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        model_reset();
        tick(3);
        check_all("R1 reset after use");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule